// File: doc/BRIEF.md
# Comma-Detect Word Aligner

This block turns a serial stream of 8b/10b symbols into aligned 10-bit parallel words. One bit is taken on each system clock edge where the bit enable is high. A 10-bit window slides over the stream and is compared against both running-disparity forms of the K28.5 comma. When a comma lands off the current word boundary and alignment is enabled, the boundary moves so that the symbol after the comma starts a fresh word.

Each finished word is presented together with a toggle of a pair of antiphase byte clocks, so successive words fall on alternate clocks. A sync flag marks every word that is itself a comma. The byte clocks are never shortened. A realignment stretches the phase that is running by the bits already gathered into the abandoned word. A loop-back select routes the transmit serial bit into the receiver, and while it is set the external serial output is parked at a fixed level.

Top module: `comma_word_aligner`

## Requirements
- R1: Every output word holds ten consecutive received bits, and rx_word[0] is the earliest of them.
- R2: rx_word and sync_flag change only on a clock edge that takes the tenth bit of a word with bit_en high, and each such edge toggles byte_clk0. After the n-th word since reset (n counted from 1), byte_clk0 equals n mod 2. With bit_en low, no output changes.
- R3: byte_clk1 is always the complement of byte_clk0. After reset, byte_clk0 is 0 and byte_clk1 is 1.
- R4: Every byte-clock phase lasts at least 10 and at most 20 bit times. A realignment caused by a comma that completes k bits into a word (k from 1 to 9) stretches the phase in progress to 10+k bit times.
- R5: Both comma forms are recognised. Written as rx_word values they are 10'h17C (first bits received 0,0,1,1,1,1,1,0,1,0) and 10'h283 (1,1,0,0,0,0,0,1,0,1). A comma that fills a word exactly raises sync_flag for that one word, and sync_flag is low for every other word.
- R6: With sync_en high, a comma that does not end on the word boundary causes the partial word in progress to be discarded without being output. The symbol after that comma becomes the next output word, and all later symbols, including the next comma, come out aligned.
- R7: With sync_en low, the word boundary never moves. An off-boundary comma neither stretches a clock phase nor raises sync_flag.
- R8: A comma that falls on the current boundary leaves the boundary where it is and causes no stretch.
- R9: With loop_en high, the receiver takes tx_bit, ignores rx_bit, and tx_line is held at 1. With loop_en low, the receiver takes rx_bit and tx_line follows tx_bit.
- R10: After reset, rx_word is 0, sync_flag is 0, and the first word starts with the first bit taken after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Qualifies one serial bit on this clock edge |
| rx_bit | input | 1 | Serial receive bit |
| tx_bit | input | 1 | Serial transmit bit |
| loop_en | input | 1 | Routes tx_bit into the receiver and parks tx_line |
| sync_en | input | 1 | Allows the word boundary to follow commas |
| tx_line | output | 1 | External serial output |
| rx_word | output | 10 | Aligned parallel word, bit 0 received first |
| sync_flag | output | 1 | High while rx_word is a comma on the boundary |
| byte_clk0 | output | 1 | Receive byte clock, toggles with each word |
| byte_clk1 | output | 1 | Complement of byte_clk0 |

## Verification
A word, its sync flag and the byte-clock toggle all appear at the clock edge that takes the word's tenth bit with bit_en high. There is no further pipeline stage, and tx_line follows its inputs with no register. The bench drives each bit at a falling edge, lets one rising edge take it, and samples every output at the next falling edge. Byte-clock phase lengths are counted in bench bits between observed toggles. Each bit is followed by an idle cycle with bit_en low, which shows that nothing moves without the enable.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  localparam int unsigned SYM_W = 10;

  // Comma values as held in a word whose bit 0 arrived first.
  localparam logic [SYM_W-1:0] COMMA_RDN = 10'h17C;
  localparam logic [SYM_W-1:0] COMMA_RDP = 10'h283;

  function automatic logic is_comma(input logic [SYM_W-1:0] w);
    return (w == COMMA_RDN) || (w == COMMA_RDP);
  endfunction

  // The newest bit enters at the top, so after SYM_W shifts bit 0 is the oldest.
  function automatic logic [SYM_W-1:0] shift_in(input logic [SYM_W-1:0] h, input logic b);
    return {b, h[SYM_W-1:1]};
  endfunction

endpackage

// File: rtl/aligner_src_sel.sv
module aligner_src_sel #(
  parameter logic LINE_IDLE = 1'b1
) (
  input  logic loop_en,
  input  logic rx_bit,
  input  logic tx_bit,
  output logic rx_src,
  output logic tx_line
);

  always_comb begin
    if (loop_en) begin
      rx_src  = tx_bit;
      tx_line = LINE_IDLE;
    end else begin
      rx_src  = rx_bit;
      tx_line = tx_bit;
    end
  end

endmodule

// File: rtl/aligner_comma_det.sv
module aligner_comma_det
  import aligner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             din,
  output logic [SYM_W-1:0] window_nxt,
  output logic             comma_hit
);

  logic [SYM_W-1:0] window_q;

  assign window_nxt = shift_in(window_q, din);
  assign comma_hit  = bit_en && is_comma(window_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      window_q <= '0;
    else if (bit_en) window_q <= window_nxt;
  end

  // R2: the window moves only when a bit is qualified
  assert_window_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(window_q));

endmodule

// File: rtl/aligner_framer.sv
module aligner_framer
  import aligner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sync_en,
  input  logic [SYM_W-1:0] window_nxt,
  input  logic             comma_hit,
  output logic [SYM_W-1:0] rx_word,
  output logic             sync_flag,
  output logic             byte_clk0,
  output logic             byte_clk1
);

  localparam int unsigned CW = $clog2(SYM_W);
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);
  localparam int unsigned PHASE_MAX = 2 * SYM_W;
  localparam int unsigned PW = $clog2(PHASE_MAX + 2) + 1;

  logic [CW-1:0] cnt;
  logic          word_done;
  logic          realign;

  assign word_done = bit_en && (cnt == LAST);
  assign realign   = comma_hit && sync_en && (cnt != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx_word   <= '0;
      sync_flag <= 1'b0;
      byte_clk0 <= 1'b0;
      byte_clk1 <= 1'b1;
    end else if (bit_en) begin
      if (realign) begin
        cnt <= '0;
      end else if (word_done) begin
        cnt       <= '0;
        rx_word   <= window_nxt;
        sync_flag <= comma_hit;
        byte_clk0 <= ~byte_clk0;
        byte_clk1 <= ~byte_clk1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Phase-length counter used by the checks below.
  logic [PW-1:0] phase_bits;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       phase_bits <= '0;
    else if (bit_en && word_done)     phase_bits <= '0;
    else if (bit_en && phase_bits != '1) phase_bits <= phase_bits + 1'b1;
  end

  assert_clk_antiphase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_clk0 != byte_clk1);

  assert_phase_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !realign) |-> (phase_bits >= PW'(SYM_W - 1)));

  assert_phase_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !realign) |-> (phase_bits <= PW'(PHASE_MAX - 1)));

  assert_sync_is_comma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flag |-> is_comma(rx_word));

  assert_word_with_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> !$stable(byte_clk0));

  assert_fixed_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && bit_en && cnt != LAST) |=> (cnt == CW'($past(cnt) + 1'b1)));

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import aligner_pkg::*;
#(
  parameter logic LINE_IDLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             tx_bit,
  input  logic             loop_en,
  input  logic             sync_en,
  output logic             tx_line,
  output logic [SYM_W-1:0] rx_word,
  output logic             sync_flag,
  output logic             byte_clk0,
  output logic             byte_clk1
);

  logic             rx_src;
  logic [SYM_W-1:0] window_nxt;
  logic             comma_hit;

  aligner_src_sel #(.LINE_IDLE(LINE_IDLE)) u_src (
    .loop_en (loop_en),
    .rx_bit  (rx_bit),
    .tx_bit  (tx_bit),
    .rx_src  (rx_src),
    .tx_line (tx_line)
  );

  aligner_comma_det u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .din        (rx_src),
    .window_nxt (window_nxt),
    .comma_hit  (comma_hit)
  );

  aligner_framer u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .sync_en    (sync_en),
    .window_nxt (window_nxt),
    .comma_hit  (comma_hit),
    .rx_word    (rx_word),
    .sync_flag  (sync_flag),
    .byte_clk0  (byte_clk0),
    .byte_clk1  (byte_clk1)
  );

  // R9: in loop-back the receiver follows the transmit bit
  assert_loop_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rx_src == tx_bit));

endmodule

// File: tb/tb_comma_word_aligner.sv
module tb_comma_word_aligner;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, tx_bit = 1'b0, loop_en = 1'b0, sync_en = 1'b0;
  logic tx_line, sync_flag, byte_clk0, byte_clk1;
  logic [9:0] rx_word;

  always #4 clk = ~clk;

  comma_word_aligner dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .tx_bit(tx_bit),
    .loop_en(loop_en), .sync_en(sync_en), .tx_line(tx_line), .rx_word(rx_word),
    .sync_flag(sync_flag), .byte_clk0(byte_clk0), .byte_clk1(byte_clk1)
  );

  int checks = 0;
  int errors = 0;

  logic stream [0:127];
  int   nbits;
  logic [9:0] cap_word [0:15];
  logic       cap_sync [0:15];
  int         cap_len  [0:15];
  int         ncap;
  int         since;
  logic       prev_clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] word_at(input int s);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[i] = stream[s + i];
    return w;
  endfunction

  function automatic logic comma_val(input logic [9:0] w);
    return (w == 10'h17C) || (w == 10'h283);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; tx_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ncap = 0; since = 0; prev_clk = 1'b0;
    // R10 and R3: reset state
    check(rx_word == 10'd0, "R10 word", rx_word, 0);
    check(sync_flag == 1'b0, "R10 sync", sync_flag, 0);
    check(byte_clk0 == 1'b0 && byte_clk1 == 1'b1, "R3 reset clocks", {byte_clk0, byte_clk1}, 1);
  endtask

  task automatic push_sym(input logic [9:0] s);
    for (int i = 0; i < 10; i++) begin stream[nbits] = s[i]; nbits++; end
  endtask

  task automatic play(input logic lp);
    logic [9:0] held;
    for (int i = 0; i < nbits; i++) begin
      if (lp) begin tx_bit = stream[i]; rx_bit = ~stream[i]; end
      else begin rx_bit = stream[i]; tx_bit = i[0]; end
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      since++;
      if (lp) check(tx_line == 1'b1, "R9 idle line", tx_line, 1);
      else    check(tx_line == tx_bit, "R9 line follows", tx_line, tx_bit);
      check(byte_clk1 == ~byte_clk0, "R3 antiphase", byte_clk1, ~byte_clk0);
      if (byte_clk0 != prev_clk) begin
        if (ncap < 16) begin
          cap_word[ncap] = rx_word; cap_sync[ncap] = sync_flag; cap_len[ncap] = since;
        end
        ncap++;
        check(byte_clk0 == ncap[0], "R2 clock parity", byte_clk0, ncap[0]);
        prev_clk = byte_clk0;
        since = 0;
      end
      held = rx_word;
      @(negedge clk);
      check(rx_word == held && byte_clk0 == prev_clk, "R2 hold without enable", rx_word, held);
    end
  endtask

  task automatic run_case(input int k, input logic pol, input logic se, input logic lp);
    logic [9:0] cm;
    int starts [0:4];
    logic realigned;
    do_reset();
    sync_en = se; loop_en = lp;
    cm = pol ? 10'h283 : 10'h17C;
    nbits = 0;
    for (int i = 0; i < k; i++) begin stream[nbits] = pol; nbits++; end
    push_sym(cm); push_sym(10'h2AA); push_sym(10'h155); push_sym(cm); push_sym(10'h2AA);
    play(lp);
    realigned = se && (k != 0);
    for (int j = 0; j < 5; j++) starts[j] = (realigned && j > 0) ? k + 10 * j : 10 * j;
    check(ncap == 5, "R2 word count", ncap, 5);
    for (int j = 0; j < 5 && j < ncap; j++) begin
      logic [9:0] ew;
      int el;
      ew = word_at(starts[j]);
      el = (realigned && j == 1) ? 10 + k : 10;
      // R1 bit order, R6 realigned content, R7 fixed boundary
      check(cap_word[j] == ew, realigned ? "R6 word" : (se ? "R1 word" : "R7 word"), cap_word[j], ew);
      check(cap_sync[j] == comma_val(ew), se ? "R5 sync" : "R7 sync", cap_sync[j], comma_val(ew));
      check(cap_len[j] == el, realigned ? "R4 stretch" : "R8 no stretch", cap_len[j], el);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 10; k++)
        run_case(k, p[0], 1'b1, 1'b0);
    run_case(3, 1'b0, 1'b0, 1'b0);
    run_case(7, 1'b1, 1'b0, 1'b0);
    run_case(4, 1'b1, 1'b1, 1'b1);
    run_case(0, 1'b0, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule